// File: doc/BRIEF.md
# Logical Device Resource Register File

This block holds the per-device resource settings of a card that exposes several logical devices behind one index/data configuration port. While the card controller has the card in its configuration state (`cfg_en` high), software picks a device with `dev_sel`, places a register index on `cfg_index` and writes or reads one byte. The block keeps, for each device, an activation flag, a conflict-probe control, eight 16-bit I/O base addresses, two interrupt entries and two DMA channel entries. It presents them, decoded, as flat output vectors for the rest of the card.

The block also answers reads on the host I/O bus during a conflict probe. When a device is inactive and its probe is enabled, a host read that lands in one of its programmed port windows makes the block drive a fixed byte, 0x55 or 0xAA, so that firmware can find overlapping assignments before it turns the device on. A device cannot be switched on while its probe is enabled.

Every interface is a single-cycle strobe interface with no back-pressure. A write strobe is accepted on the clock edge where it is seen. Read data on `cfg_rdata` and the probe answer on `io_drive`/`io_data` follow the inputs combinationally in the same cycle, so no ready signal is needed.

Top module: `ldev_resource_file`

## Requirements
- R1: After `rst_n` low, or one cycle after a `cfg_reset` pulse, every register of every device is zero: all devices are inactive, the probe is off, bases are 0x0000, interrupt entries are 0 and both DMA entries select channel 0.
- R2: Writing index 0x30 sets the activation flag of the selected device from data bit 0. A read of 0x30 returns the flag in bit 0 and zero in bits 7..1, and `dev_active[i]` shows the flag of device i.
- R3: Index 0x31 stores data bit 1 as probe enable and data bit 0 as probe pattern select. A read returns them in bits 1 and 0, with bits 7..2 zero.
- R4: A write of 1 to bit 0 of index 0x30 while that device's probe is enabled is ignored, and the flag stays 0. Writing 0 is always accepted.
- R5: When `io_rd` is high and some device is inactive, has its probe enabled and has a nonzero base B with B <= `io_addr` < B+8, then `io_drive` is 1 in the same cycle. `io_data` is then 0x55 if that device's pattern bit is 1, else 0xAA.
- R6: `io_drive` is 0 and `io_data` is 0x00 when the device is active, the probe is off, the base is zero or the address is outside every 8-port window.
- R7: I/O range k (0..7) sits at index 0x60+2k (address bits 15..8) and 0x61+2k (bits 7..0). Both bytes read back, and range k of device i appears on `io_base[(i*8+k)*16 +: 16]`.
- R8: Interrupt entry j (0..1) keeps a 4-bit level at 0x70+2j (bits 3..0) and a control byte at 0x71+2j, where bit 1 = active-high polarity and bit 0 = level-triggered. Unused bits read 0. Outputs are `irq_level[(i*2+j)*4 +: 4]`, `irq_high[i*2+j]` and `irq_level_trig[i*2+j]`.
- R9: DMA entry d (0..1) keeps a 3-bit channel at 0x74+d (bits 2..0, upper bits read 0), shown on `dma_chan[(i*2+d)*3 +: 3]`. `dma_used[i*2+d]` is 0 exactly when the channel is 4.
- R10: Writes take effect only when `cfg_en` is high, and only in the device named by `dev_sel`. Other devices and writes made while `cfg_en` is low leave state unchanged.
- R11: When several devices' windows match one probe read, the lowest-numbered matching device sets the pattern.
- R12: Indices not listed above read as 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_reset | input | 1 | One-cycle pulse that clears all device registers |
| cfg_en | input | 1 | Card is in its configuration state; gates writes |
| dev_sel | input | SELW | Selected logical device |
| cfg_index | input | 8 | Register index |
| cfg_wr | input | 1 | Write strobe |
| cfg_wdata | input | 8 | Write data |
| cfg_rdata | output | 8 | Read data of selected device at `cfg_index` |
| io_rd | input | 1 | Host I/O read strobe |
| io_addr | input | 16 | Host I/O address |
| io_drive | output | 1 | Block answers the current host read |
| io_data | output | 8 | Probe answer byte |
| dev_active | output | NDEV | Activation flag per device |
| io_base | output | NDEV*128 | Eight 16-bit I/O bases per device |
| irq_level | output | NDEV*8 | Two 4-bit interrupt levels per device |
| irq_high | output | NDEV*2 | Interrupt polarity, 1 = high |
| irq_level_trig | output | NDEV*2 | Interrupt type, 1 = level |
| dma_chan | output | NDEV*6 | Two 3-bit DMA channels per device |
| dma_used | output | NDEV*2 | DMA entry selects a real channel (not 4) |

## Verification
A corrupted register shows in the same cycle on the decoded output vectors and on `cfg_rdata` when its index is read back. A wrong activation or probe flag shows on the next host read of a programmed window, because `io_drive` and `io_data` follow it combinationally. The checks therefore read back each register class at once after writing it and then probe window edges (B-1, B, B+7, B+8). Device selection and the `cfg_en` gate are checked by reading the devices that should be untouched.

// File: rtl/ldev_pkg.sv
package ldev_pkg;
  localparam int NUM_IO   = 8;
  localparam int NUM_IRQ  = 2;
  localparam int NUM_DMA  = 2;
  localparam int IO_SPAN  = 8;
  localparam logic [7:0] IDX_ACT = 8'h30;
  localparam logic [7:0] IDX_RC  = 8'h31;
  localparam logic [3:0] IOB_HI  = 4'h6;   // 0x60..0x6F
  localparam logic [5:0] IRQ_HI  = 6'h1C;  // 0x70..0x73
  localparam logic [6:0] DMA_HI  = 7'h3A;  // 0x74..0x75
  localparam logic [2:0] DMA_NONE = 3'd4;
  localparam logic [7:0] PAT_ONE  = 8'h55;
  localparam logic [7:0] PAT_ZERO = 8'hAA;

  typedef struct packed {
    logic act;
    logic rc_en;
    logic rc_pat;
  } ldev_ctl_t;
endpackage

// File: rtl/ldev_regs.sv
module ldev_regs
  import ldev_pkg::*;
(
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      clr,
  input  logic                      wr,
  input  logic [7:0]                idx,
  input  logic [7:0]                wdata,
  output logic [7:0]                rdata,
  output ldev_ctl_t                 ctl,
  output logic [NUM_IO*16-1:0]      base_o,
  output logic [NUM_IRQ*4-1:0]      lvl_o,
  output logic [NUM_IRQ-1:0]        hi_o,
  output logic [NUM_IRQ-1:0]        lt_o,
  output logic [NUM_DMA*3-1:0]      dma_o
);
  ldev_ctl_t   ctl_q;
  logic [15:0] base_q [NUM_IO];
  logic [3:0]  lvl_q  [NUM_IRQ];
  logic [1:0]  ictl_q [NUM_IRQ];
  logic [2:0]  dma_q  [NUM_DMA];

  logic hit_iob, hit_irq, hit_dma;
  assign hit_iob = (idx[7:4] == IOB_HI);
  assign hit_irq = (idx[7:2] == IRQ_HI);
  assign hit_dma = (idx[7:1] == DMA_HI);

  always_ff @(posedge clk) begin
    if (!rst_n || clr) begin
      ctl_q <= '0;
      for (int k = 0; k < NUM_IO; k++)  base_q[k] <= '0;
      for (int j = 0; j < NUM_IRQ; j++) begin lvl_q[j] <= '0; ictl_q[j] <= '0; end
      for (int d = 0; d < NUM_DMA; d++) dma_q[d] <= '0;
    end else if (wr) begin
      if (idx == IDX_ACT) begin
        if (!wdata[0] || !ctl_q.rc_en) ctl_q.act <= wdata[0];
      end else if (idx == IDX_RC) begin
        ctl_q.rc_en  <= wdata[1];
        ctl_q.rc_pat <= wdata[0];
      end else if (hit_iob) begin
        if (idx[0]) base_q[idx[3:1]][7:0]  <= wdata;
        else        base_q[idx[3:1]][15:8] <= wdata;
      end else if (hit_irq) begin
        if (idx[0]) ictl_q[idx[1]] <= wdata[1:0];
        else        lvl_q[idx[1]]  <= wdata[3:0];
      end else if (hit_dma) begin
        dma_q[idx[0]] <= wdata[2:0];
      end
    end
  end

  always_comb begin
    rdata = '0;
    if (idx == IDX_ACT)      rdata[0]   = ctl_q.act;
    else if (idx == IDX_RC)  rdata[1:0] = {ctl_q.rc_en, ctl_q.rc_pat};
    else if (hit_iob)        rdata = idx[0] ? base_q[idx[3:1]][7:0] : base_q[idx[3:1]][15:8];
    else if (hit_irq)        rdata = idx[0] ? {6'b0, ictl_q[idx[1]]} : {4'b0, lvl_q[idx[1]]};
    else if (hit_dma)        rdata = {5'b0, dma_q[idx[0]]};
  end

  assign ctl = ctl_q;
  for (genvar k = 0; k < NUM_IO; k++) begin : g_base
    assign base_o[k*16 +: 16] = base_q[k];
  end
  for (genvar j = 0; j < NUM_IRQ; j++) begin : g_irq
    assign lvl_o[j*4 +: 4] = lvl_q[j];
    assign hi_o[j] = ictl_q[j][1];
    assign lt_o[j] = ictl_q[j][0];
  end
  for (genvar d = 0; d < NUM_DMA; d++) begin : g_dma
    assign dma_o[d*3 +: 3] = dma_q[d];
  end

  // R4: a set request while the probe is on leaves the device off
  a_r4_act_blocked: assert property (@(posedge clk) disable iff (!rst_n)
    (wr && !clr && idx == IDX_ACT && wdata[0] && ctl_q.rc_en && !ctl_q.act) |=> !ctl_q.act);
  // R2: the flag can only rise after a cycle with the probe off
  a_r2_rise_needs_off: assert property (@(posedge clk) disable iff (!rst_n)
    (ctl_q.act && !$past(ctl_q.act)) |-> !$past(ctl_q.rc_en));
  // R1: clear pulse empties the controls and DMA entries
  a_r1_clear: assert property (@(posedge clk) disable iff (!rst_n)
    clr |=> (ctl_q == '0 && dma_o == '0 && base_o == '0));
endmodule

// File: rtl/ldev_range_probe.sv
module ldev_range_probe
  import ldev_pkg::*;
(
  input  logic                 armed,
  input  logic [NUM_IO*16-1:0] base_i,
  input  logic [15:0]          addr,
  output logic                 hit
);
  logic [NUM_IO-1:0] win;
  for (genvar k = 0; k < NUM_IO; k++) begin : g_win
    logic [16:0] lo, hi_ex, a;
    assign lo    = {1'b0, base_i[k*16 +: 16]};
    assign hi_ex = lo + 17'(IO_SPAN);
    assign a     = {1'b0, addr};
    assign win[k] = (lo != '0) && (a >= lo) && (a < hi_ex);
  end
  assign hit = armed && (|win);
endmodule

// File: rtl/ldev_resource_file.sv
module ldev_resource_file
  import ldev_pkg::*;
#(
  parameter int NDEV = 2,
  localparam int SELW = (NDEV > 1) ? $clog2(NDEV) : 1
) (
  input  logic                      clk,
  input  logic                      rst_n,
  input  logic                      cfg_reset,
  input  logic                      cfg_en,
  input  logic [SELW-1:0]           dev_sel,
  input  logic [7:0]                cfg_index,
  input  logic                      cfg_wr,
  input  logic [7:0]                cfg_wdata,
  output logic [7:0]                cfg_rdata,
  input  logic                      io_rd,
  input  logic [15:0]               io_addr,
  output logic                      io_drive,
  output logic [7:0]                io_data,
  output logic [NDEV-1:0]           dev_active,
  output logic [NDEV*NUM_IO*16-1:0] io_base,
  output logic [NDEV*NUM_IRQ*4-1:0] irq_level,
  output logic [NDEV*NUM_IRQ-1:0]   irq_high,
  output logic [NDEV*NUM_IRQ-1:0]   irq_level_trig,
  output logic [NDEV*NUM_DMA*3-1:0] dma_chan,
  output logic [NDEV*NUM_DMA-1:0]   dma_used
);
  logic [7:0]  rd_arr [NDEV];
  ldev_ctl_t   ctl    [NDEV];
  logic [NDEV-1:0] hit;

  for (genvar i = 0; i < NDEV; i++) begin : g_dev
    logic wr_i;
    assign wr_i = cfg_wr && cfg_en && (dev_sel == SELW'(i));
    ldev_regs u_regs (
      .clk(clk), .rst_n(rst_n), .clr(cfg_reset), .wr(wr_i),
      .idx(cfg_index), .wdata(cfg_wdata), .rdata(rd_arr[i]), .ctl(ctl[i]),
      .base_o(io_base[i*NUM_IO*16 +: NUM_IO*16]),
      .lvl_o(irq_level[i*NUM_IRQ*4 +: NUM_IRQ*4]),
      .hi_o(irq_high[i*NUM_IRQ +: NUM_IRQ]),
      .lt_o(irq_level_trig[i*NUM_IRQ +: NUM_IRQ]),
      .dma_o(dma_chan[i*NUM_DMA*3 +: NUM_DMA*3])
    );
    ldev_range_probe u_probe (
      .armed(ctl[i].rc_en && !ctl[i].act),
      .base_i(io_base[i*NUM_IO*16 +: NUM_IO*16]),
      .addr(io_addr), .hit(hit[i])
    );
    assign dev_active[i] = ctl[i].act;
    for (genvar d = 0; d < NUM_DMA; d++) begin : g_du
      assign dma_used[i*NUM_DMA+d] = (dma_chan[(i*NUM_DMA+d)*3 +: 3] != DMA_NONE);
    end
  end

  always_comb begin
    cfg_rdata = '0;
    for (int i = 0; i < NDEV; i++)
      if (dev_sel == SELW'(i)) cfg_rdata = rd_arr[i];
  end

  // lowest-numbered matching device wins (R11)
  always_comb begin
    io_drive = 1'b0;
    io_data  = '0;
    for (int i = NDEV-1; i >= 0; i--) begin
      if (io_rd && hit[i]) begin
        io_drive = 1'b1;
        io_data  = ctl[i].rc_pat ? PAT_ONE : PAT_ZERO;
      end
    end
  end

  a_r5_drive_needs_read: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive |-> io_rd);
  a_r5_pattern: assert property (@(posedge clk) disable iff (!rst_n)
    io_drive |-> (io_data == PAT_ONE || io_data == PAT_ZERO));
  a_r6_quiet_data: assert property (@(posedge clk) disable iff (!rst_n)
    !io_drive |-> (io_data == 8'h00));
  a_r6_active_silent: assert property (@(posedge clk) disable iff (!rst_n)
    (&dev_active) |-> !io_drive);
  a_r10_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    (!cfg_en && !cfg_reset) |=> ($stable(dev_active) && $stable(io_base) && $stable(dma_chan)));
endmodule

// File: tb/ldev_resource_file_test.sv
module ldev_resource_file_test;
  localparam int NDEV = 2;

  logic clk = 0, rst_n = 0, cfg_reset = 0, cfg_en = 0, cfg_wr = 0, io_rd = 0;
  logic [0:0] dev_sel = '0;
  logic [7:0] cfg_index = '0, cfg_wdata = '0, cfg_rdata, io_data;
  logic [15:0] io_addr = '0;
  logic io_drive;
  logic [NDEV-1:0] dev_active;
  logic [NDEV*128-1:0] io_base;
  logic [NDEV*8-1:0] irq_level;
  logic [NDEV*2-1:0] irq_high, irq_level_trig, dma_used;
  logic [NDEV*6-1:0] dma_chan;

  ldev_resource_file #(.NDEV(NDEV)) uut (.*);

  always #10 clk = ~clk;

  typedef struct { bit is_io; logic [8:0] exp; string tag; } item_t;
  item_t sb[$];
  int n_cmp = 0, n_bad = 0;
  bit probe = 0, done = 0;

  // monitor: compares results at the falling edge
  always @(negedge clk) begin
    if (probe || io_rd) begin
      if (sb.size() == 0) begin
        n_cmp++; n_bad++;
        $display("FAIL scoreboard empty (no requirement) got cfg=%h io=%b/%h exp none", cfg_rdata, io_drive, io_data);
      end else begin
        item_t it;
        logic [8:0] got;
        it = sb.pop_front();
        got = it.is_io ? {io_drive, io_data} : {1'b0, cfg_rdata};
        n_cmp++;
        if (got !== it.exp) begin
          n_bad++;
          $display("FAIL %s actual=%h expected=%h", it.tag, got, it.exp);
        end
      end
    end
  end

  task automatic wr(input int d, input logic [7:0] idx, input logic [7:0] v);
    @(posedge clk); #1;
    dev_sel = 1'(d); cfg_index = idx; cfg_wdata = v; cfg_wr = 1;
    @(posedge clk); #1 cfg_wr = 0;
  endtask

  task automatic rd(input int d, input logic [7:0] idx, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    dev_sel = 1'(d); cfg_index = idx;
    it.is_io = 0; it.exp = {1'b0, e}; it.tag = tag; sb.push_back(it);
    probe = 1;
    @(posedge clk); #1 probe = 0;
  endtask

  task automatic io(input logic [15:0] a, input bit drv, input logic [7:0] e, input string tag);
    item_t it;
    @(posedge clk); #1;
    io_addr = a; io_rd = 1;
    it.is_io = 1; it.exp = {drv, drv ? e : 8'h00}; it.tag = tag; sb.push_back(it);
    @(posedge clk); #1 io_rd = 0;
  endtask

  task automatic chk(input logic [31:0] got, input logic [31:0] e, input string tag);
    @(negedge clk);
    n_cmp++;
    if (got !== e) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", tag, got, e);
    end
  endtask

  task automatic summary();
    if (!done) begin
      done = 1;
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog expired (all requirements) actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1; cfg_en = 1;
    // R1 reset state
    rd(0, 8'h30, 8'h00, "R1 act after reset");
    rd(1, 8'h74, 8'h00, "R1 dma after reset");
    chk(32'(dev_active), 0, "R1 dev_active");
    chk(32'(dma_used), 32'hF, "R1 dma_used");
    // R7 I/O bases
    wr(0, 8'h60, 8'h02); wr(0, 8'h61, 8'h20);
    wr(0, 8'h6E, 8'h03); wr(0, 8'h6F, 8'h40);
    rd(0, 8'h60, 8'h02, "R7 base0 high");
    rd(0, 8'h61, 8'h20, "R7 base0 low");
    rd(0, 8'h6F, 8'h40, "R7 base7 low");
    chk(32'(io_base[15:0]), 32'h0220, "R7 io_base range0");
    chk(32'(io_base[7*16 +: 16]), 32'h0340, "R7 io_base range7");
    // R3 / R5 probe
    wr(0, 8'h31, 8'hFF);
    rd(0, 8'h31, 8'h03, "R3 probe readback");
    io(16'h0220, 1, 8'h55, "R5 window start");
    io(16'h0227, 1, 8'h55, "R5 window end");
    io(16'h0345, 1, 8'h55, "R5 range7 window");
    io(16'h0228, 0, 8'h00, "R6 past window");
    io(16'h021F, 0, 8'h00, "R6 below window");
    wr(0, 8'h31, 8'h02);
    io(16'h0220, 1, 8'hAA, "R5 pattern AA");
    // R4 blocked activation
    wr(0, 8'h30, 8'h01);
    rd(0, 8'h30, 8'h00, "R4 activation ignored");
    chk(32'(dev_active), 0, "R4 dev_active");
    // R2 activation
    wr(0, 8'h31, 8'h00);
    io(16'h0220, 0, 8'h00, "R6 probe off");
    wr(0, 8'hFF & 8'h30, 8'hFF);
    rd(0, 8'h30, 8'h01, "R2 act readback");
    chk(32'(dev_active), 1, "R2 dev_active");
    wr(0, 8'h31, 8'h02);
    io(16'h0220, 0, 8'h00, "R6 active silent");
    wr(0, 8'h30, 8'h00);
    io(16'h0220, 1, 8'hAA, "R5 after deactivate");
    io(16'h0003, 0, 8'h00, "R6 zero base");
    // R11 / R10 second device
    wr(1, 8'h60, 8'h02); wr(1, 8'h61, 8'h20); wr(1, 8'h31, 8'h03);
    io(16'h0220, 1, 8'hAA, "R11 lowest device wins");
    rd(0, 8'h31, 8'h02, "R10 other device untouched");
    io(16'h0334, 0, 8'h00, "R6 outside all windows");
    // R8 interrupts
    wr(0, 8'h70, 8'h1B); wr(0, 8'h71, 8'hFF);
    wr(0, 8'h72, 8'h05); wr(0, 8'h73, 8'h01);
    rd(0, 8'h70, 8'h0B, "R8 level readback");
    rd(0, 8'h71, 8'h03, "R8 control readback");
    chk(32'(irq_level[7:0]), 32'h5B, "R8 irq_level");
    chk(32'(irq_high[1:0]), 32'h1, "R8 irq_high");
    chk(32'(irq_level_trig[1:0]), 32'h3, "R8 irq_level_trig");
    // R9 DMA
    wr(0, 8'h74, 8'h04); wr(0, 8'h75, 8'hFD);
    rd(0, 8'h74, 8'h04, "R9 dma0 readback");
    rd(0, 8'h75, 8'h05, "R9 dma1 readback");
    chk(32'(dma_chan[5:0]), 32'h2C, "R9 dma_chan");
    chk(32'(dma_used[1:0]), 32'h2, "R9 dma_used");
    // R10 gate
    cfg_en = 0;
    wr(0, 8'h74, 8'h01);
    rd(0, 8'h74, 8'h04, "R10 write with cfg_en low");
    cfg_en = 1;
    // R12 unassigned
    rd(0, 8'h40, 8'h00, "R12 unassigned index");
    // R1 clear pulse
    @(posedge clk); #1 cfg_reset = 1;
    @(posedge clk); #1 cfg_reset = 0;
    rd(0, 8'h60, 8'h00, "R1 base cleared");
    rd(0, 8'h31, 8'h00, "R1 probe cleared");
    rd(1, 8'h31, 8'h00, "R1 dev1 probe cleared");
    chk(32'(dma_used), 32'hF, "R1 dma channel 0 after clear");
    io(16'h0220, 0, 8'h00, "R1 no answer after clear");
    repeat (2) @(posedge clk);
    if (sb.size() != 0) begin
      n_cmp++; n_bad++;
      $display("FAIL scoreboard leftover (all requirements) actual=%0d expected=0", sb.size());
    end
    summary();
  end
endmodule